// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block resolves a 48-bit virtual address into a physical address after a translation-cache miss. It walks a radix tree of four 512-entry tables in memory. The walk starts at the table named by the root-pointer input, and each level selects its entry with a 9-bit slice of the virtual address, taking the most significant slice first. Every table entry is 64 bits wide. The walker issues one read per level through a single-outstanding request/response memory port and decodes each entry as it arrives. A clear present flag ends the walk with a fault that reports the level. A large-page flag at the third level ends the walk early with a 2 MB mapping. At the leaf, the walker sets the entry's accessed flag in memory when that flag was clear.

The controller is an enumerated state machine with five states. `ST_IDLE` waits for a request. `ST_RD_REQ` presents a table read. `ST_RD_WAIT` waits for its data. `ST_WB_REQ` presents the accessed-flag write. `ST_DONE` presents the result for one cycle. The named transitions are:
- accept: `ST_IDLE` to `ST_RD_REQ`
- issue: `ST_RD_REQ` to `ST_RD_WAIT`
- descend: `ST_RD_WAIT` to `ST_RD_REQ`
- leaf-dirty: `ST_RD_WAIT` to `ST_WB_REQ`
- leaf-clean or fault: `ST_RD_WAIT` to `ST_DONE`
- written: `ST_WB_REQ` to `ST_DONE`
- retire: `ST_DONE` to `ST_IDLE`

Top module: `ptw_core`

## Requirements
- R1: After reset the walker is idle. `req_ready` is 1, while `mem_req_valid` and `done_valid` are 0.
- R2: At level L (0 to 3), the entry address is the table base plus 8 times the index. The index is `req_va[47:39]`, `[38:30]`, `[29:21]` or `[20:12]` for L = 0, 1, 2 or 3. The level-0 base is `root_base`, and each deeper base is the previous entry's bits 51:12 followed by twelve zero bits.
- R3: Entry bit 0 is the present flag. If a fetched entry has bit 0 clear, the walk ends with `done_fault`=1 and `done_level` equal to the level of that entry, and no write is issued.
- R4: A present entry at level 3 is a 4 KB leaf. The walk then takes exactly 4 reads and returns `done_pa` = {entry[51:12], va[11:0]} with `done_level`=3 and `done_large`=0.
- R5: Entry bit 7 set in a present level-2 entry makes a 2 MB leaf. The walk then takes 3 reads and returns `done_pa` = {entry[51:21], va[20:0]} with `done_level`=2 and `done_large`=1. Bit 7 at levels 0 and 1 has no effect, and the walk descends.
- R6: Entry bit 5 is the accessed flag. If it is clear in the leaf, exactly one write is made to the leaf entry's address, with data equal to the entry with bit 5 set, before the result. If it is already set, no write is made.
- R7: A memory request is held with a stable address and direction until `mem_req_ready`. No new request is issued while a read response is outstanding.
- R8: `req_ready` is high only when idle, so requests arriving during a walk are ignored. Each accepted request yields exactly one `done_valid` pulse, one cycle long.
- R9: `mem_req_write` is 1 only for the accessed-flag write. Walks that end in a fault or on a leaf whose accessed flag is already set issue reads only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base | input | 52 | Physical base of the level-0 table |
| req_valid | input | 1 | Translation request |
| req_va | input | 48 | Virtual address to translate |
| req_ready | output | 1 | Walker idle, request accepted |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 52 | Byte address of the entry |
| mem_req_wdata | output | 64 | Write data (entry with accessed flag) |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 64 | Read data |
| done_valid | output | 1 | Result pulse |
| done_fault | output | 1 | Walk ended on a non-present entry |
| done_level | output | 2 | Level of the final entry |
| done_pa | output | 52 | Translated physical address |
| done_large | output | 1 | Result is a 2 MB mapping |

## Verification
Every cycle, the assertions check the port protocol:
- a held request stays stable until accepted;
- no request is issued while a read is outstanding;
- the result pulse lasts one cycle;
- no memory or result activity occurs while idle;
- every write carries the accessed and present flags.

Some behaviours only the bench scenarios can show. These are the index arithmetic, the entry decoding, the per-level fault reporting, the early end for large pages, and whether a write-back is made or skipped. The bench shows them against a prepared table image and checks the number of reads per walk and the data written back.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WB_REQ,
        ST_DONE
    } walk_state_t;

    // Entry flag positions
    localparam int PTE_PRESENT_BIT  = 0;
    localparam int PTE_ACCESSED_BIT = 5;
    localparam int PTE_LARGE_BIT    = 7;
endpackage

// File: rtl/ptw_index.sv
module ptw_index #(
    parameter int VA_W        = 48,
    parameter int PA_W        = 52,
    parameter int OFF_W       = 12,
    parameter int IDX_W       = 9,
    parameter int LEVELS      = 4,
    parameter int ENTRY_BYTES = 8,
    localparam int LVL_W      = $clog2(LEVELS)
) (
    input  logic [VA_W-1:0]  va,
    input  logic [LVL_W-1:0] level,
    input  logic [PA_W-1:0]  table_base,
    output logic [PA_W-1:0]  entry_addr
);
    localparam int ESH = $clog2(ENTRY_BYTES);

    logic [IDX_W-1:0] idx_arr [LEVELS];

    // Level 0 takes the most significant slice
    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign idx_arr[g] = va[OFF_W + (LEVELS-1-g)*IDX_W +: IDX_W];
    end

    assign entry_addr = table_base + (PA_W'(idx_arr[level]) << ESH);
endmodule

// File: rtl/ptw_entry_dec.sv
module ptw_entry_dec #(
    parameter int PA_W        = 52,
    parameter int OFF_W       = 12,
    parameter int IDX_W       = 9,
    parameter int LEVELS      = 4,
    parameter int ENTRY_W     = 64,
    parameter int LARGE_LEVEL = 2,
    localparam int LVL_W      = $clog2(LEVELS),
    localparam int BIG_OFF_W  = OFF_W + IDX_W
) (
    input  logic [ENTRY_W-1:0]   entry,
    input  logic [LVL_W-1:0]     level,
    input  logic [BIG_OFF_W-1:0] va_low,
    output logic                 present,
    output logic                 accessed,
    output logic                 is_large,
    output logic                 is_leaf,
    output logic [PA_W-1:0]      next_base,
    output logic [PA_W-1:0]      leaf_pa,
    output logic [ENTRY_W-1:0]   wb_data
);
    import ptw_pkg::*;

    assign present   = entry[PTE_PRESENT_BIT];
    assign accessed  = entry[PTE_ACCESSED_BIT];
    assign is_large  = entry[PTE_LARGE_BIT] && (level == LVL_W'(LARGE_LEVEL));
    assign is_leaf   = is_large || (level == LVL_W'(LEVELS-1));
    assign next_base = {entry[PA_W-1:OFF_W], {OFF_W{1'b0}}};
    assign leaf_pa   = is_large ? {entry[PA_W-1:BIG_OFF_W], va_low}
                                : {entry[PA_W-1:OFF_W], va_low[OFF_W-1:0]};
    assign wb_data   = entry | (ENTRY_W'(1) << PTE_ACCESSED_BIT);
endmodule

// File: rtl/ptw_core.sv
module ptw_core #(
    parameter int VA_W        = 48,
    parameter int PA_W        = 52,
    parameter int OFF_W       = 12,
    parameter int IDX_W       = 9,
    parameter int LEVELS      = 4,
    parameter int ENTRY_W     = 64,
    parameter int LARGE_LEVEL = 2,
    localparam int LVL_W      = $clog2(LEVELS),
    localparam int BIG_OFF_W  = OFF_W + IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PA_W-1:0]    root_base,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_va,
    output logic               req_ready,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic               mem_req_write,
    output logic [PA_W-1:0]    mem_req_addr,
    output logic [ENTRY_W-1:0] mem_req_wdata,
    input  logic               mem_rsp_valid,
    input  logic [ENTRY_W-1:0] mem_rsp_rdata,
    output logic               done_valid,
    output logic               done_fault,
    output logic [LVL_W-1:0]   done_level,
    output logic [PA_W-1:0]    done_pa,
    output logic               done_large
);
    import ptw_pkg::*;

    walk_state_t state_q, state_d;

    logic [VA_W-1:0]    va_q;
    logic [PA_W-1:0]    base_q;
    logic [LVL_W-1:0]   level_q;
    logic               fault_q;
    logic               large_q;
    logic [PA_W-1:0]    pa_q;
    logic [ENTRY_W-1:0] wb_q;

    logic [PA_W-1:0]    entry_addr;
    logic               d_present, d_accessed, d_large, d_leaf;
    logic [PA_W-1:0]    d_next_base, d_leaf_pa;
    logic [ENTRY_W-1:0] d_wb_data;

    ptw_index #(
        .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
        .LEVELS(LEVELS), .ENTRY_BYTES(ENTRY_W/8)
    ) u_index (
        .va         (va_q),
        .level      (level_q),
        .table_base (base_q),
        .entry_addr (entry_addr)
    );

    ptw_entry_dec #(
        .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS),
        .ENTRY_W(ENTRY_W), .LARGE_LEVEL(LARGE_LEVEL)
    ) u_dec (
        .entry     (mem_rsp_rdata),
        .level     (level_q),
        .va_low    (va_q[BIG_OFF_W-1:0]),
        .present   (d_present),
        .accessed  (d_accessed),
        .is_large  (d_large),
        .is_leaf   (d_leaf),
        .next_base (d_next_base),
        .leaf_pa   (d_leaf_pa),
        .wb_data   (d_wb_data)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid)     state_d = ST_RD_REQ;   // accept
            ST_RD_REQ:  if (mem_req_ready) state_d = ST_RD_WAIT;  // issue
            ST_RD_WAIT: if (mem_rsp_valid) begin
                if (!d_present)     state_d = ST_DONE;            // fault
                else if (!d_leaf)   state_d = ST_RD_REQ;          // descend
                else if (d_accessed) state_d = ST_DONE;           // leaf-clean
                else                state_d = ST_WB_REQ;          // leaf-dirty
            end
            ST_WB_REQ:  if (mem_req_ready) state_d = ST_DONE;     // written
            ST_DONE:                       state_d = ST_IDLE;     // retire
            default:                       state_d = ST_IDLE;
        endcase
    end

    // Walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q    <= '0;
            base_q  <= '0;
            level_q <= '0;
            fault_q <= 1'b0;
            large_q <= 1'b0;
            pa_q    <= '0;
            wb_q    <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            va_q    <= req_va;
            base_q  <= root_base;
            level_q <= '0;
            fault_q <= 1'b0;
            large_q <= 1'b0;
            pa_q    <= '0;
        end else if (state_q == ST_RD_WAIT && mem_rsp_valid) begin
            if (!d_present) begin
                fault_q <= 1'b1;
            end else if (d_leaf) begin
                pa_q    <= d_leaf_pa;
                large_q <= d_large;
                wb_q    <= d_wb_data;
            end else begin
                base_q  <= d_next_base;
                level_q <= level_q + LVL_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_RD_REQ) || (state_q == ST_WB_REQ);
        mem_req_write = (state_q == ST_WB_REQ);
        mem_req_addr  = entry_addr;
        mem_req_wdata = (state_q == ST_WB_REQ) ? wb_q : '0;
        done_valid    = (state_q == ST_DONE);
        done_fault    = fault_q;
        done_level    = level_q;
        done_pa       = pa_q;
        done_large    = large_q;
    end
endmodule

// File: rtl/ptw_core_chk.sv
module ptw_core_chk #(
    parameter int PA_W    = 52,
    parameter int ENTRY_W = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_ready,
    input logic               mem_req_valid,
    input logic               mem_req_ready,
    input logic               mem_req_write,
    input logic [PA_W-1:0]    mem_req_addr,
    input logic [ENTRY_W-1:0] mem_req_wdata,
    input logic               mem_rsp_valid,
    input logic               done_valid
);
    import ptw_pkg::*;

    logic rd_out;
    always_ff @(posedge clk) begin
        if (!rst_n)                                              rd_out <= 1'b0;
        else if (mem_req_valid && mem_req_ready && !mem_req_write) rd_out <= 1'b1;
        else if (mem_rsp_valid)                                  rd_out <= 1'b0;
    end

    assert_hold_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

    assert_single_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_out |-> !mem_req_valid);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid && !done_valid);

    assert_wb_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_write |->
            mem_req_wdata[PTE_ACCESSED_BIT] && mem_req_wdata[PTE_PRESENT_BIT]);
endmodule

bind ptw_core ptw_core_chk #(.PA_W(PA_W), .ENTRY_W(ENTRY_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .done_valid    (done_valid)
);

// File: tb/ptw_core_bench.sv
`timescale 1ns/1ps
module ptw_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [51:0] root_base = 52'h1000;
    logic        req_valid = 1'b0;
    logic [47:0] req_va = '0;
    logic        req_ready;
    logic        mem_req_valid, mem_req_write;
    logic        mem_req_ready = 1'b0;
    logic [51:0] mem_req_addr;
    logic [63:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_rdata = '0;
    logic        done_valid, done_fault, done_large;
    logic [1:0]  done_level;
    logic [51:0] done_pa;

    always #5 clk = ~clk;

    ptw_core u_ptw_core (
        .clk(clk), .rst_n(rst_n), .root_base(root_base),
        .req_valid(req_valid), .req_va(req_va), .req_ready(req_ready),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .done_valid(done_valid),
        .done_fault(done_fault), .done_level(done_level),
        .done_pa(done_pa), .done_large(done_large)
    );

    // Table image and memory model
    logic [63:0] pt_mem [logic [51:0]];
    int          rd_cnt = 0, wr_cnt = 0, cyc = 0, overlap = 0, dly = 0;
    logic        pend = 1'b0;
    logic [51:0] paddr = '0, last_waddr = '0;
    logic [63:0] last_wdata = '0;

    function automatic logic [63:0] mem_read(input logic [51:0] a);
        return pt_mem.exists(a) ? pt_mem[a] : 64'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rsp_valid <= 1'b0;
            mem_req_ready <= 1'b0;
            pend <= 1'b0;
        end else begin
            mem_rsp_valid <= 1'b0;
            if (pend) begin
                if (dly == 0) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_rdata <= mem_read(paddr);
                    pend <= 1'b0;
                end else dly <= dly - 1;
            end
            if (mem_req_valid && mem_req_ready) begin
                if (pend) overlap <= overlap + 1;
                if (mem_req_write) begin
                    pt_mem[mem_req_addr] = mem_req_wdata;
                    wr_cnt <= wr_cnt + 1;
                    last_waddr <= mem_req_addr;
                    last_wdata <= mem_req_wdata;
                end else begin
                    pend <= 1'b1;
                    paddr <= mem_req_addr;
                    dly <= cyc % 4;
                    rd_cnt <= rd_cnt + 1;
                end
            end
            mem_req_ready <= (cyc % 3) != 1;
            cyc <= cyc + 1;
        end
    end

    typedef struct packed {
        logic [47:0] va;
        logic        fault;
        logic [1:0]  level;
        logic [51:0] pa;
        logic [2:0]  reads;
        logic        wb;
        logic [51:0] waddr;
        logic [63:0] wdata;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{48'h0080_8060_4123, 1'b0, 2'd3, 52'hABCDE123,         3'd4, 1'b1, 52'h4020, 64'hABCDE021},
        '{48'h0080_8060_4123, 1'b0, 2'd3, 52'hABCDE123,         3'd4, 1'b0, 52'h0,    64'h0},
        '{48'h0080_80A1_ABCD, 1'b0, 2'd2, 52'h4061ABCD,         3'd3, 1'b1, 52'h3028, 64'h406000A1},
        '{48'h0380_0000_0000, 1'b1, 2'd0, 52'h0,                3'd1, 1'b0, 52'h0,    64'h0},
        '{48'h0080_8060_9000, 1'b1, 2'd3, 52'h0,                3'd4, 1'b0, 52'h0,    64'h0},
        '{48'h0081_8000_0000, 1'b1, 2'd1, 52'h0,                3'd2, 1'b0, 52'h0,    64'h0},
        '{48'h0081_0000_0FFF, 1'b0, 2'd3, 52'h77777FFF,         3'd4, 1'b0, 52'h0,    64'h0},
        '{48'h0080_8060_5ABC, 1'b0, 2'd3, 52'hF_FFFF_FFFF_FABC, 3'd4, 1'b1, 52'h4028, 64'h000F_FFFF_FFFF_F021}
    };

    int n_checks = 0, n_fail = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    logic        r_fault, r_large, r_timeout;
    logic [1:0]  r_level;
    logic [51:0] r_pa;
    int          r_reads, r_writes;

    task automatic walk(input logic [47:0] va, input bit poke_busy);
        int rd0, wr0, wd;
        @(negedge clk);
        rd0 = rd_cnt; wr0 = wr_cnt;
        req_va = va; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke_busy) begin
            check("R8 busy req_ready", {63'd0, req_ready}, 64'd0);
            req_va = 48'h0380_0000_0000; req_valid = 1'b1;
            @(negedge clk);
            @(negedge clk);
            req_valid = 1'b0;
        end
        wd = 0; r_timeout = 1'b0;
        while (!done_valid) begin
            @(negedge clk);
            wd++;
            if (wd > 1000) begin r_timeout = 1'b1; break; end
        end
        if (r_timeout) begin
            n_checks++; n_fail++;
            $display("FAIL R8 watchdog: actual no result expected done_valid");
        end
        r_fault = done_fault; r_level = done_level; r_pa = done_pa; r_large = done_large;
        r_reads = rd_cnt - rd0; r_writes = wr_cnt - wr0;
        @(negedge clk);
        check("R8 done one cycle", {63'd0, done_valid}, 64'd0);
    endtask

    initial begin
        pt_mem[52'h1008] = 64'h2001;
        pt_mem[52'h2010] = 64'h3001;
        pt_mem[52'h3018] = 64'h4001;
        pt_mem[52'h4020] = 64'hABCDE001;
        pt_mem[52'h3028] = 64'h40600081;
        pt_mem[52'h2020] = 64'h5081;                // large flag at level 1: ignored
        pt_mem[52'h5000] = 64'h6001;
        pt_mem[52'h6000] = 64'h77777021;            // accessed already set
        pt_mem[52'h4028] = 64'h000F_FFFF_FFFF_F001;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 req_ready", {63'd0, req_ready}, 64'd1);
        check("R1 mem_req_valid", {63'd0, mem_req_valid}, 64'd0);
        check("R1 done_valid", {63'd0, done_valid}, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            walk(VECS[i].va, 1'b0);
            check("R3 fault", {63'd0, r_fault}, {63'd0, VECS[i].fault});
            check("R3 level", {62'd0, r_level}, {62'd0, VECS[i].level});
            check("R2 read count", 64'(r_reads), 64'(VECS[i].reads));
            if (!VECS[i].fault) begin
                check("R4 R5 pa", {12'd0, r_pa}, {12'd0, VECS[i].pa});
                check("R5 large", {63'd0, r_large}, {63'd0, VECS[i].level == 2'd2});
            end
            check("R6 R9 write count", 64'(r_writes), {63'd0, VECS[i].wb});
            if (VECS[i].wb) begin
                check("R6 write addr", {12'd0, last_waddr}, {12'd0, VECS[i].waddr});
                check("R6 write data", last_wdata, VECS[i].wdata);
            end
        end

        // R8: request during a walk is ignored
        walk(48'h0081_0000_0FFF, 1'b1);
        check("R8 busy result pa", {12'd0, r_pa}, 64'h77777FFF);
        check("R8 busy fault", {63'd0, r_fault}, 64'd0);
        repeat (4) @(negedge clk);
        check("R8 no extra walk", {63'd0, req_ready}, 64'd1);

        // R7: never a second request while a read is pending
        check("R7 overlap", 64'(overlap), 64'd0);

        // Root pointer moves: R2 with a different level-0 base
        root_base = 52'h8000;
        pt_mem[52'h8008] = 64'h2001;
        walk(48'h0080_8060_4123, 1'b0);
        check("R2 new root pa", {12'd0, r_pa}, 64'hABCDE123);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R8 global watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule